// File: doc/BRIEF.md
# Smart Card Transmit-End Flag Controller

This block owns the transmit-end status flag of a smart card character transmitter working in the ISO 7816 asynchronous style. It does not shift any data. Instead it watches status from the rest of the transmitter: character start and character end pulses from the shifter, the transmit-data-empty flag, the error-signal status bit, and the transmit-enable, guard-mode and block-mode control bits. From these it decides when the line has gone quiet long enough to report that transmission has finished.

A character is one start bit, eight data bits and one parity bit. The shifter pulses `char_end_i` at the end of the parity bit. From that point the block counts half-etu ticks on `half_tick_i` before it raises the flag. The count depends on the mode bits: with guard mode set it is 2 ticks (1.0 etu); with guard mode clear and block mode set it is 3 ticks (1.5 etu); with both clear it is 5 ticks (2.5 etu). Software clears the flag in two steps: it reads the status register while data-empty is 1, then writes 0 to the data-empty bit. A DMA write to the data register clears the flag directly.

Top module: `sc_txend_ctrl`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `lowpwr_i` high, `tend_o` is 1. Low power also discards any running count, pending set and latched read.
- R2: In a cycle with `tx_en_i`=0 and `err_sig_i`=0, `tend_o` is 1 from the next cycle on.
- R3: With guard=0 and block=0, `tend_o` rises on the clock edge that samples the 5th `half_tick_i` pulse after `char_end_i`, provided `tdre_i`=1 and `err_sig_i`=0. It is still 0 after the 4th pulse.
- R4: With guard=0 and block=1, the same rise happens on the 3rd half-etu tick after `char_end_i`.
- R5: With guard=1, the rise happens on the 2nd half-etu tick after `char_end_i`, whatever the block bit is.
- R6: `char_start_i` clears `tend_o` and cancels a running count. Ticks that follow it do not set the flag until a new `char_end_i` has been seen and its count has run out.
- R7: A status read (`sr_rd_i`) taken while `tdre_i`=1 arms a latch. A later status write (`sr_wr_i`) with `sr_wr_tdre_i`=0 then clears `tend_o` on the next cycle. Any status write releases the latch.
- R8: A status write of 0 to the data-empty bit with no armed latch leaves `tend_o` unchanged. A read taken while `tdre_i`=0 does not arm the latch.
- R9: A pulse on `dma_wr_i` clears `tend_o` on the next cycle.
- R10: If `err_sig_i`=1 when the count runs out, `tend_o` stays 0. It rises one cycle after `err_sig_i` returns to 0 while `tdre_i`=1.
- R11: Priority, highest first: low power set, transmit-disabled set (R2), clear events (R6, R7, R9), count completion set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lowpwr_i | input | 1 | Standby or module-stop mode active |
| half_tick_i | input | 1 | One-cycle pulse every half etu |
| tx_en_i | input | 1 | Transmit enable control bit |
| err_sig_i | input | 1 | Error-signal status bit |
| tdre_i | input | 1 | Transmit-data-empty flag value |
| guard_i | input | 1 | Guard mode control bit |
| block_i | input | 1 | Block mode control bit |
| char_start_i | input | 1 | Pulse: shifter begins a character |
| char_end_i | input | 1 | Pulse: end of the parity bit |
| sr_rd_i | input | 1 | Status register read strobe |
| sr_wr_i | input | 1 | Status register write strobe |
| sr_wr_tdre_i | input | 1 | Value written to the data-empty bit |
| dma_wr_i | input | 1 | DMA write strobe to the data register |
| tend_o | output | 1 | Transmit-end flag |

## Verification
Every result is registered once. A change on any control input shows on `tend_o` after the next rising edge. A count that is N ticks long shows its result after the edge that samples the Nth tick. The bench drives inputs on the falling edge and samples `tend_o` on the next falling edge, so each check lands exactly one edge after its stimulus. For the counted delays the bench checks the flag after tick N-1 (it must still be 0) and again after tick N (it must be 1). Random idle gaps between the ticks show that only ticks advance the count.

// File: rtl/txend_pkg.sv
package txend_pkg;

  // Why the flag changed in a cycle, in priority order
  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_LOWPWR = 3'd1,
    CAUSE_TEOFF  = 3'd2,
    CAUSE_CLEAR  = 3'd3,
    CAUSE_DONE   = 3'd4,
    CAUSE_PEND   = 3'd5
  } tend_cause_e;

  // Quiet time after parity, in half-etu ticks
  function automatic int unsigned half_etu_delay(input logic guard, input logic blk);
    if (guard)    return 2;
    else if (blk) return 3;
    else          return 5;
  endfunction

endpackage

// File: rtl/txend_delay_cnt.sv
module txend_delay_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (flush_i)                cnt_q <= '0;
    else if (load_i)                 cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign done_o = tick_i && (cnt_q == ONE) && !load_i && !flush_i;
endmodule

// File: rtl/txend_clr_qual.sv
module txend_clr_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic lowpwr_i,
  input  logic tdre_i,
  input  logic sr_rd_i,
  input  logic sr_wr_i,
  input  logic sr_wr_tdre_i,
  input  logic dma_wr_i,
  output logic rd_seen_o,
  output logic clr_o
);
  logic rd_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_seen_q <= 1'b0;
    else if (lowpwr_i)          rd_seen_q <= 1'b0;
    else if (sr_wr_i)           rd_seen_q <= 1'b0;
    else if (sr_rd_i && tdre_i) rd_seen_q <= 1'b1;
  end

  assign rd_seen_o = rd_seen_q;
  assign clr_o     = dma_wr_i || (sr_wr_i && !sr_wr_tdre_i && rd_seen_q);
endmodule

// File: rtl/sc_txend_ctrl.sv
module sc_txend_ctrl
  import txend_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lowpwr_i,
  input  logic half_tick_i,
  input  logic tx_en_i,
  input  logic err_sig_i,
  input  logic tdre_i,
  input  logic guard_i,
  input  logic block_i,
  input  logic char_start_i,
  input  logic char_end_i,
  input  logic sr_rd_i,
  input  logic sr_wr_i,
  input  logic sr_wr_tdre_i,
  input  logic dma_wr_i,
  output logic tend_o
);
  logic             cnt_done;
  logic             clr_evt;
  logic             rd_seen;
  logic             te_off_set;
  logic             tend_q;
  logic             pend_q;
  logic [CNT_W-1:0] dly_ticks;
  tend_cause_e      cause;

  assign dly_ticks  = CNT_W'(half_etu_delay(guard_i, block_i));
  assign te_off_set = !tx_en_i && !err_sig_i;

  txend_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (lowpwr_i || char_start_i),
    .load_i     (char_end_i),
    .load_val_i (dly_ticks),
    .tick_i     (half_tick_i),
    .done_o     (cnt_done)
  );

  txend_clr_qual u_clr (
    .clk          (clk),
    .rst_n        (rst_n),
    .lowpwr_i     (lowpwr_i),
    .tdre_i       (tdre_i),
    .sr_rd_i      (sr_rd_i),
    .sr_wr_i      (sr_wr_i),
    .sr_wr_tdre_i (sr_wr_tdre_i),
    .dma_wr_i     (dma_wr_i),
    .rd_seen_o    (rd_seen),
    .clr_o        (clr_evt)
  );

  always_comb begin
    if (lowpwr_i)                              cause = CAUSE_LOWPWR;
    else if (te_off_set)                       cause = CAUSE_TEOFF;
    else if (clr_evt || char_start_i)          cause = CAUSE_CLEAR;
    else if (cnt_done)                         cause = CAUSE_DONE;
    else if (pend_q && tdre_i && !err_sig_i)   cause = CAUSE_PEND;
    else                                       cause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      unique case (cause)
        CAUSE_LOWPWR, CAUSE_TEOFF, CAUSE_PEND: begin
          tend_q <= 1'b1;
          pend_q <= 1'b0;
        end
        CAUSE_CLEAR: begin
          tend_q <= 1'b0;
          pend_q <= 1'b0;
        end
        CAUSE_DONE: begin
          if (tdre_i && !err_sig_i) tend_q <= 1'b1;
          else                      pend_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign tend_o = tend_q;
endmodule

// File: rtl/sc_txend_ctrl_chk.sv
module sc_txend_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic lowpwr_i,
  input logic tx_en_i,
  input logic err_sig_i,
  input logic char_start_i,
  input logic sr_wr_i,
  input logic sr_wr_tdre_i,
  input logic dma_wr_i,
  input logic rd_seen,
  input logic tend_o
);
  AST_LOWPWR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    lowpwr_i |=> tend_o); // R1

  AST_TEOFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_i && !err_sig_i) |=> tend_o); // R2

  AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr_i && tx_en_i && !lowpwr_i) |=> !tend_o); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_start_i && tx_en_i && !lowpwr_i) |=> !tend_o); // R6

  AST_UNARMED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && !sr_wr_tdre_i && !rd_seen && !dma_wr_i && !char_start_i && tend_o)
      |=> tend_o); // R8

  AST_ARMED_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && !sr_wr_tdre_i && rd_seen && tx_en_i && !lowpwr_i) |=> !tend_o); // R7

  AST_NO_RISE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend_o) |-> ($past(lowpwr_i) || !$past(err_sig_i))); // R10
endmodule

bind sc_txend_ctrl sc_txend_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lowpwr_i     (lowpwr_i),
  .tx_en_i      (tx_en_i),
  .err_sig_i    (err_sig_i),
  .char_start_i (char_start_i),
  .sr_wr_i      (sr_wr_i),
  .sr_wr_tdre_i (sr_wr_tdre_i),
  .dma_wr_i     (dma_wr_i),
  .rd_seen      (rd_seen),
  .tend_o       (tend_o)
);

// File: tb/sc_txend_ctrl_bench.sv
module sc_txend_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lowpwr_i = 0, half_tick_i = 0, tx_en_i = 1, err_sig_i = 0, tdre_i = 1;
  logic guard_i = 0, block_i = 0, char_start_i = 0, char_end_i = 0;
  logic sr_rd_i = 0, sr_wr_i = 0, sr_wr_tdre_i = 1, dma_wr_i = 0;
  logic tend_o;

  int n_run = 0;
  int n_fail = 0;
  int unsigned seed = 32'h5C7E_0017;

  always #2 clk = ~clk; // 250 MHz

  sc_txend_ctrl u_sc_txend_ctrl (.*);

  function automatic int exp_ticks(input logic g, input logic b);
    int etu_x2;
    etu_x2 = g ? 2 : (b ? 3 : 5);
    return etu_x2;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tend_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic tick(); half_tick_i = 1; cyc(); half_tick_i = 0; endtask
  task automatic dma_clr(); dma_wr_i = 1; cyc(); dma_wr_i = 0; endtask
  task automatic lp_set(); lowpwr_i = 1; cyc(); lowpwr_i = 0; endtask
  task automatic start_char(); char_start_i = 1; cyc(); char_start_i = 0; endtask
  task automatic end_char(input logic g, input logic b);
    guard_i = g; block_i = b; char_end_i = 1; cyc(); char_end_i = 0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: tend_o=%b expected finish", tend_o);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) cyc();
    chk("R1 reset", tend_o, 1'b1);
    rst_n = 1; cyc();
    chk("R1 after reset", tend_o, 1'b1);

    dma_clr();
    chk("R9 dma clear", tend_o, 1'b0);
    tx_en_i = 0; cyc(); tx_en_i = 1;
    chk("R2 te off set", tend_o, 1'b1);

    lp_set();
    chk("R1 low power", tend_o, 1'b1);
    sr_wr_i = 1; sr_wr_tdre_i = 0; cyc(); sr_wr_i = 0; sr_wr_tdre_i = 1;
    chk("R8 write without read", tend_o, 1'b1);
    tdre_i = 0; sr_rd_i = 1; cyc(); sr_rd_i = 0; tdre_i = 1;
    sr_wr_i = 1; sr_wr_tdre_i = 0; cyc(); sr_wr_i = 0; sr_wr_tdre_i = 1;
    chk("R8 read saw 0", tend_o, 1'b1);
    sr_rd_i = 1; cyc(); sr_rd_i = 0;
    cyc();
    chk("R7 armed, not yet written", tend_o, 1'b1);
    sr_wr_i = 1; sr_wr_tdre_i = 0; cyc(); sr_wr_i = 0; sr_wr_tdre_i = 1;
    chk("R7 read-then-write clear", tend_o, 1'b0);
    lp_set();
    sr_wr_i = 1; sr_wr_tdre_i = 0; cyc(); sr_wr_i = 0; sr_wr_tdre_i = 1;
    chk("R7 latch released by write", tend_o, 1'b1);

    dma_clr();
    end_char(0, 0);
    tick(); tick();
    start_char();
    chk("R6 start clears", tend_o, 1'b0);
    repeat (6) tick();
    chk("R6 count cancelled", tend_o, 1'b0);
    end_char(1, 0);
    tick(); tick();
    chk("R6 restart completes", tend_o, 1'b1);

    dma_clr();
    end_char(0, 1);
    err_sig_i = 1;
    repeat (3) tick();
    chk("R10 held by error", tend_o, 1'b0);
    cyc();
    chk("R10 still held", tend_o, 1'b0);
    err_sig_i = 0; cyc();
    chk("R10 set after error drop", tend_o, 1'b1);

    dma_wr_i = 1; lowpwr_i = 1; cyc(); dma_wr_i = 0; lowpwr_i = 0;
    chk("R11 low power over dma", tend_o, 1'b1);
    dma_wr_i = 1; tx_en_i = 0; cyc(); dma_wr_i = 0; tx_en_i = 1;
    chk("R11 te off over dma", tend_o, 1'b1);
    dma_clr();
    end_char(1, 1);
    tick();
    dma_wr_i = 1; half_tick_i = 1; cyc(); dma_wr_i = 0; half_tick_i = 0;
    chk("R11 clear over done", tend_o, 1'b0);

    for (int it = 0; it < 30; it++) begin
      logic g, b;
      int n;
      g = 1'($urandom_range(0, 1));
      b = 1'($urandom_range(0, 1));
      n = exp_ticks(g, b);
      dma_clr();
      start_char();
      repeat ($urandom_range(0, 4)) cyc();
      end_char(g, b);
      for (int k = 1; k <= n; k++) begin
        repeat ($urandom_range(0, 3)) cyc();
        tick();
        if (k == n - 1) begin
          if (g)      chk("R5 before last tick", tend_o, 1'b0);
          else if (b) chk("R4 before last tick", tend_o, 1'b0);
          else        chk("R3 before last tick", tend_o, 1'b0);
        end
      end
      if (g)      chk("R5 delay 2 ticks", tend_o, 1'b1);
      else if (b) chk("R4 delay 3 ticks", tend_o, 1'b1);
      else        chk("R3 delay 5 ticks", tend_o, 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule